// File: doc/BRIEF.md
# RV32 Instruction Compressor

This block takes one 32-bit base-integer instruction word per cycle and checks whether a 16-bit compressed encoding exists for it. If one does, the block emits that 16-bit encoding in the low half of its output word and raises a compressed flag. If none does, the original word goes out unchanged with the flag low. An assembler back end or an instruction-stream packer can use it to shrink code before layout. It does not fix branch or jump offsets after code shrinks, pack halfwords into a stream, or decompress.

Each candidate is chosen by its opcode and function fields. The choice is then gated by four kinds of check: whether two registers are equal, whether a register is the zero register, whether a register lies in the eight-register window x8 to x15, and whether the immediate fits the compressed field. For the window registers, x8 is encoded as 3'b000 and x15 as 3'b111. Once a form is chosen, the datapath scatters the immediate into that form's non-contiguous bit layout.

The parameter `OUT_REG` sets the latency. At its default of 1, the outputs are registered and the result appears one clock after the input. At 0, the outputs follow the input combinationally.

Top module: `rvc_compressor`

## Requirements
- R1: With `OUT_REG`=1, `outValid` equals `inValid` from the previous clock edge. While reset is asserted, `outValid` and `outCompressed` are 0. `outCompressed` is never 1 while `outValid` is 0.
- R2: When a valid word cannot be compressed, `outWord` equals the input word unchanged and `outCompressed` is 0.
- R3: When `outCompressed` is 1, `outWord[31:16]` is zero and `outWord[1:0]` is not 2'b11.
- R4: add (opcode 0110011, funct3 000, funct7 0) with rs1=x0, rd≠0 and rs2≠0 gives {1000,rd,rs2,10}. With rd=rs1≠0 and rs2≠0 it gives {1001,rd,rs2,10}.
- R5: jalr (opcode 1100111, funct3 000) with offset 0 and rs1≠0 gives {1000,rs1,00000,10} when rd=x0 and {1001,rs1,00000,10} when rd=x1. No other rd compresses.
- R6: addi (opcode 0010011, funct3 000) with rs1=x0, rd≠0 and imm in −32..31 gives {010,imm[5],rd,imm[4:0],01}. Otherwise, rd=rs1≠0 with a nonzero imm in −32..31 gives {000,imm[5],rd,imm[4:0],01}.
- R7: lui (opcode 0110111) with rd not x0 or x2 and a nonzero 20-bit immediate in −32..31 gives {011,imm[5],rd,imm[4:0],01}.
- R8: When rd=rs1 and funct7 is legal, the shift and and-immediate forms compress. slli (funct3 001) needs rd≠0 and gives {000,0,rd,shamt,10}. The remaining forms need rd in x8..x15 and all give {100,b12,sel,rd',low5,01}. srli (funct3 101, funct7 0) has sel 00. srai (funct3 101, funct7 0100000) has sel 01. andi (funct3 111, imm in −32..31) has sel 10.
- R9: lw (opcode 0000011, funct3 010) and sw (opcode 0100011, funct3 010) compress when every register is in x8..x15 and the offset is a multiple of 4 in 0..124. They give {010 or 110, off[5:3], base', off[2], off[6], data', 00}.
- R10: sub, xor, or and and with rd=rs1 and both registers in x8..x15 give {100011,rd',sel,rs2',01}, where sel is 00, 01, 10 and 11 respectively.
- R11: beq (funct3 000) and bne (funct3 001) with rs2=x0, rs1 in x8..x15 and an offset in −256..254 give {110 or 111, off[8], off[4:3], rs1', off[7:6], off[2:1], off[5], 01}.
- R12: jal with rd x0 or x1 and an offset in −2048..2046 gives {101 or 001, off[11], off[4], off[9:8], off[10], off[6], off[7], off[3:1], off[5], 01}.
- R13: No other opcode, funct3 or funct7 combination is compressed. This includes the byte and halfword loads and stores, other branch conditions, and add-type words with other funct7 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word is valid this cycle |
| inWord | input | 32 | Instruction word to examine |
| outValid | output | 1 | Result is valid |
| outCompressed | output | 1 | Result holds a 16-bit encoding |
| outWord | output | 32 | Compressed halfword (zero-extended) or original word |

## Verification
The assertions check the cycle-level contract on every clock. They cover the valid latency, a flag that never rises while idle, unchanged pass-through, a zero upper half on compressed results, and the rule that words outside the eight eligible opcodes never compress. Whether the chosen form is the correct one, whether each immediate range is honoured at its boundary, and whether the scattered bits land in the right places can only be shown by the bench's sweeps. Those sweeps cover registers, boundary immediates and excluded registers, and compare each result with an arithmetic model.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int ILEN = 32;
  localparam int CLEN = 16;
  localparam int RLEN = 5;
  localparam int PLEN = 3;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] F7_BASE    = 7'b0000000;
  localparam logic [6:0] F7_ALT     = 7'b0100000;

  typedef enum logic [4:0] {
    F_NONE, F_MV, F_ADD, F_JR, F_JALR, F_LI, F_LUI, F_ADDI, F_SLLI,
    F_LW, F_SW, F_SUB, F_XOR, F_OR, F_AND, F_BEQZ, F_BNEZ,
    F_SRLI, F_SRAI, F_ANDI, F_J, F_JAL
  } form_e;

  typedef struct packed {
    logic  pack;
    form_e form;
  } strobe_t;
endpackage

// File: rtl/rvc_ctrl.sv
module rvc_ctrl
  import rvc_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output strobe_t         strobe
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [RLEN-1:0] rd, rs1, rs2;

  assign opc = instr[6:0];
  assign rd  = instr[11:7];
  assign f3  = instr[14:12];
  assign rs1 = instr[19:15];
  assign rs2 = instr[24:20];
  assign f7  = instr[31:25];

  logic rdNz, rs1Nz, rs2Nz, rdEqRs1, rdP, rs1P, rs2P, aluOk, cbOk;
  assign rdNz    = |rd;
  assign rs1Nz   = |rs1;
  assign rs2Nz   = |rs2;
  assign rdEqRs1 = (rd == rs1);
  assign rdP     = (rd[4:3] == 2'b01);
  assign rs1P    = (rs1[4:3] == 2'b01);
  assign rs2P    = (rs2[4:3] == 2'b01);
  assign aluOk   = rdEqRs1 && rdP && rs2P;
  assign cbOk    = rdEqRs1 && rdP;

  // Range checks as sign-bit agreement instead of comparators
  logic immFits6, immNz, lwOffOk, swOffOk, luiFits, luiNz, brFits, jalFits;
  assign immFits6 = (&instr[31:25]) | ~(|instr[31:25]);
  assign immNz    = |instr[31:20];
  assign lwOffOk  = ~(|instr[31:27]) && ~(|instr[21:20]);
  assign swOffOk  = ~(|instr[31:27]) && ~(|instr[8:7]);
  assign luiFits  = (&instr[31:17]) | ~(|instr[31:17]);
  assign luiNz    = |instr[31:12];
  assign brFits   = (&{instr[31], instr[7], instr[30:28]}) |
                    ~(|{instr[31], instr[7], instr[30:28]});
  assign jalFits  = (&{instr[31], instr[19:12], instr[20]}) |
                    ~(|{instr[31], instr[19:12], instr[20]});

  form_e form;

  always_comb begin
    form = F_NONE;
    case (opc)
      OPC_OP: begin
        if (f7 == F7_BASE) begin
          case (f3)
            3'b000: begin
              if (!rs1Nz && rdNz && rs2Nz)        form = F_MV;
              else if (rdEqRs1 && rdNz && rs2Nz)  form = F_ADD;
            end
            3'b100: if (aluOk) form = F_XOR;
            3'b110: if (aluOk) form = F_OR;
            3'b111: if (aluOk) form = F_AND;
            default: ;
          endcase
        end else if (f7 == F7_ALT && f3 == 3'b000 && aluOk) begin
          form = F_SUB;
        end
      end
      OPC_JALR: begin
        if (f3 == 3'b000 && !immNz && rs1Nz) begin
          if (rd == 5'd0)      form = F_JR;
          else if (rd == 5'd1) form = F_JALR;
        end
      end
      OPC_OPIMM: begin
        case (f3)
          3'b000: begin
            if (!rs1Nz && rdNz && immFits6)                form = F_LI;
            else if (rdEqRs1 && rdNz && immNz && immFits6) form = F_ADDI;
          end
          3'b001: if (f7 == F7_BASE && rdEqRs1 && rdNz) form = F_SLLI;
          3'b101: begin
            if (f7 == F7_BASE && cbOk)     form = F_SRLI;
            else if (f7 == F7_ALT && cbOk) form = F_SRAI;
          end
          3'b111: if (cbOk && immFits6) form = F_ANDI;
          default: ;
        endcase
      end
      OPC_LUI: if (rdNz && rd != 5'd2 && luiNz && luiFits) form = F_LUI;
      OPC_LOAD: if (f3 == 3'b010 && rdP && rs1P && lwOffOk) form = F_LW;
      OPC_STORE: if (f3 == 3'b010 && rs1P && rs2P && swOffOk) form = F_SW;
      OPC_BRANCH: begin
        if (!rs2Nz && rs1P && brFits) begin
          if (f3 == 3'b000)      form = F_BEQZ;
          else if (f3 == 3'b001) form = F_BNEZ;
        end
      end
      OPC_JAL: begin
        if (jalFits) begin
          if (rd == 5'd0)      form = F_J;
          else if (rd == 5'd1) form = F_JAL;
        end
      end
      default: ;
    endcase
  end

  assign strobe.form = form;
  assign strobe.pack = (form != F_NONE);
endmodule

// File: rtl/rvc_dpath.sv
module rvc_dpath
  import rvc_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  input  strobe_t         strobe,
  output logic [ILEN-1:0] result
);
  logic [RLEN-1:0] rd, rs1, rs2;
  logic [PLEN-1:0] rdC, rs1C, rs2C;
  assign rd   = instr[11:7];
  assign rs1  = instr[19:15];
  assign rs2  = instr[24:20];
  assign rdC  = rd[PLEN-1:0];
  assign rs1C = rs1[PLEN-1:0];
  assign rs2C = rs2[PLEN-1:0];

  logic [5:0]  imm6, uimm6;
  logic [6:0]  lwOff, swOff;
  logic [12:0] brOff;
  logic [20:0] jOff;
  assign imm6  = instr[25:20];
  assign uimm6 = instr[17:12];
  assign lwOff = instr[26:20];
  assign swOff = {instr[26:25], instr[11:7]};
  assign brOff = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign jOff  = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

  logic [10:0] jField;
  assign jField = {jOff[11], jOff[4], jOff[9:8], jOff[10], jOff[6], jOff[7],
                   jOff[3:1], jOff[5]};

  logic [CLEN-1:0] enc;

  always_comb begin
    enc = '0;
    case (strobe.form)
      F_MV:   enc = {4'b1000, rd, rs2, 2'b10};
      F_ADD:  enc = {4'b1001, rd, rs2, 2'b10};
      F_JR:   enc = {4'b1000, rs1, 5'd0, 2'b10};
      F_JALR: enc = {4'b1001, rs1, 5'd0, 2'b10};
      F_LI:   enc = {3'b010, imm6[5], rd, imm6[4:0], 2'b01};
      F_LUI:  enc = {3'b011, uimm6[5], rd, uimm6[4:0], 2'b01};
      F_ADDI: enc = {3'b000, imm6[5], rd, imm6[4:0], 2'b01};
      F_SLLI: enc = {3'b000, 1'b0, rd, imm6[4:0], 2'b10};
      F_LW:   enc = {3'b010, lwOff[5:3], rs1C, lwOff[2], lwOff[6], rdC, 2'b00};
      F_SW:   enc = {3'b110, swOff[5:3], rs1C, swOff[2], swOff[6], rs2C, 2'b00};
      F_SUB:  enc = {6'b100011, rdC, 2'b00, rs2C, 2'b01};
      F_XOR:  enc = {6'b100011, rdC, 2'b01, rs2C, 2'b01};
      F_OR:   enc = {6'b100011, rdC, 2'b10, rs2C, 2'b01};
      F_AND:  enc = {6'b100011, rdC, 2'b11, rs2C, 2'b01};
      F_BEQZ: enc = {3'b110, brOff[8], brOff[4:3], rs1C, brOff[7:6], brOff[2:1], brOff[5], 2'b01};
      F_BNEZ: enc = {3'b111, brOff[8], brOff[4:3], rs1C, brOff[7:6], brOff[2:1], brOff[5], 2'b01};
      F_SRLI: enc = {3'b100, 1'b0, 2'b00, rdC, imm6[4:0], 2'b01};
      F_SRAI: enc = {3'b100, 1'b0, 2'b01, rdC, imm6[4:0], 2'b01};
      F_ANDI: enc = {3'b100, imm6[5], 2'b10, rdC, imm6[4:0], 2'b01};
      F_J:    enc = {3'b101, jField, 2'b01};
      F_JAL:  enc = {3'b001, jField, 2'b01};
      default: enc = '0;
    endcase
  end

  assign result = strobe.pack ? {{(ILEN-CLEN){1'b0}}, enc} : instr;
endmodule

// File: rtl/rvc_compressor.sv
module rvc_compressor
  import rvc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [ILEN-1:0] inWord,
  output logic            outValid,
  output logic            outCompressed,
  output logic [ILEN-1:0] outWord
);
  strobe_t         strobe;
  logic [ILEN-1:0] packedWord;

  rvc_ctrl  u_ctrl  (.instr(inWord), .strobe(strobe));
  rvc_dpath u_dpath (.instr(inWord), .strobe(strobe), .result(packedWord));

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid      <= 1'b0;
          outCompressed <= 1'b0;
          outWord       <= '0;
        end else begin
          outValid      <= inValid;
          outCompressed <= inValid & strobe.pack;
          if (inValid) outWord <= packedWord;
        end
      end
    end else begin : g_comb
      assign outValid      = inValid;
      assign outCompressed = inValid & strobe.pack;
      assign outWord       = packedWord;
    end
  endgenerate
endmodule

// File: rtl/rvc_compressor_chk.sv
module rvc_compressor_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inWord,
  input logic        outValid,
  input logic        outCompressed,
  input logic [31:0] outWord
);
  a_r1_idle_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outCompressed);

  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    outCompressed |-> (outWord[31:16] == 16'h0 && outWord[1:0] != 2'b11));

  generate
    if (OUT_REG) begin : g_reg
      a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> outValid == $past(inValid));

      a_r2_passthrough: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && outValid && !outCompressed) |-> outWord == $past(inWord));

      a_r13_foreign_opcode: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && outCompressed) |->
          ($past(inWord[6:0]) == 7'h33 || $past(inWord[6:0]) == 7'h13 ||
           $past(inWord[6:0]) == 7'h37 || $past(inWord[6:0]) == 7'h03 ||
           $past(inWord[6:0]) == 7'h23 || $past(inWord[6:0]) == 7'h63 ||
           $past(inWord[6:0]) == 7'h6f || $past(inWord[6:0]) == 7'h67));
    end else begin : g_comb
      a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
        outValid == inValid);

      a_r2_passthrough: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && !outCompressed) |-> outWord == inWord);

      a_r13_foreign_opcode: assert property (@(posedge clk) disable iff (!rstN)
        outCompressed |->
          (inWord[6:0] == 7'h33 || inWord[6:0] == 7'h13 || inWord[6:0] == 7'h37 ||
           inWord[6:0] == 7'h03 || inWord[6:0] == 7'h23 || inWord[6:0] == 7'h63 ||
           inWord[6:0] == 7'h6f || inWord[6:0] == 7'h67));
    end
  endgenerate
endmodule

bind rvc_compressor rvc_compressor_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
  .outValid(outValid), .outCompressed(outCompressed), .outWord(outWord)
);

// File: tb/sim_rvc_compressor.sv
module sim_rvc_compressor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = 32'h0;
  logic        outValid, outCompressed;
  logic [31:0] outWord;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rvc_compressor #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outCompressed(outCompressed), .outWord(outWord)
  );

  function automatic bit isP(int r);
    return r >= 8 && r <= 15;
  endfunction

  function automatic logic [2:0] pr(int r);
    logic [31:0] t;
    t = r - 8;
    return t[2:0];
  endfunction

  // Arithmetic reference: returns {compressible, halfword}
  function automatic logic [16:0] model(logic [31:0] w);
    int op, rd, rs1, rs2, f3, f7, iI, sI, bI, jI, uI;
    logic [31:0] t;
    logic [4:0] d5, s15, s25;
    logic [15:0] e;
    bit ok;
    op = w[6:0]; rd = w[11:7]; f3 = w[14:12]; rs1 = w[19:15];
    rs2 = w[24:20]; f7 = w[31:25];
    d5 = w[11:7]; s15 = w[19:15]; s25 = w[24:20];
    iI = $signed(w[31:20]);
    sI = $signed({w[31:25], w[11:7]});
    bI = $signed({w[31], w[7], w[30:25], w[11:8], 1'b0});
    jI = $signed({w[31], w[19:12], w[20], w[30:21], 1'b0});
    uI = $signed(w[31:12]);
    ok = 0; e = 16'h0;
    if (op == 'h33 && f3 == 0 && f7 == 0 && rd != 0 && rs2 != 0 && rs1 == 0) begin
      ok = 1; e = {4'b1000, d5, s25, 2'b10};
    end else if (op == 'h33 && f3 == 0 && f7 == 0 && rd != 0 && rs2 != 0 && rs1 == rd) begin
      ok = 1; e = {4'b1001, d5, s25, 2'b10};
    end else if (op == 'h33 && rd == rs1 && isP(rd) && isP(rs2) &&
                 ((f7 == 32 && f3 == 0) || (f7 == 0 && (f3 == 4 || f3 == 6 || f3 == 7)))) begin
      ok = 1;
      e = {6'b100011, pr(rd), (f3 == 0) ? 2'b00 : (f3 == 4) ? 2'b01 : (f3 == 6) ? 2'b10 : 2'b11,
           pr(rs2), 2'b01};
    end else if (op == 'h67 && f3 == 0 && iI == 0 && rs1 != 0 && (rd == 0 || rd == 1)) begin
      ok = 1; e = {(rd == 0) ? 4'b1000 : 4'b1001, s15, 5'd0, 2'b10};
    end else if (op == 'h13 && f3 == 0 && rs1 == 0 && rd != 0 && iI >= -32 && iI <= 31) begin
      t = iI; ok = 1; e = {3'b010, t[5], d5, t[4:0], 2'b01};
    end else if (op == 'h13 && f3 == 0 && rs1 == rd && rd != 0 && iI != 0 && iI >= -32 && iI <= 31) begin
      t = iI; ok = 1; e = {3'b000, t[5], d5, t[4:0], 2'b01};
    end else if (op == 'h13 && f3 == 1 && f7 == 0 && rd == rs1 && rd != 0) begin
      ok = 1; e = {3'b000, 1'b0, d5, s25, 2'b10};
    end else if (op == 'h13 && f3 == 5 && (f7 == 0 || f7 == 32) && rd == rs1 && isP(rd)) begin
      ok = 1; e = {3'b100, 1'b0, (f7 == 0) ? 2'b00 : 2'b01, pr(rd), s25, 2'b01};
    end else if (op == 'h13 && f3 == 7 && rd == rs1 && isP(rd) && iI >= -32 && iI <= 31) begin
      t = iI; ok = 1; e = {3'b100, t[5], 2'b10, pr(rd), t[4:0], 2'b01};
    end else if (op == 'h37 && rd != 0 && rd != 2 && uI != 0 && uI >= -32 && uI <= 31) begin
      t = uI; ok = 1; e = {3'b011, t[5], d5, t[4:0], 2'b01};
    end else if (op == 'h03 && f3 == 2 && isP(rd) && isP(rs1) && iI >= 0 && iI <= 124 && iI % 4 == 0) begin
      t = iI; ok = 1; e = {3'b010, t[5:3], pr(rs1), t[2], t[6], pr(rd), 2'b00};
    end else if (op == 'h23 && f3 == 2 && isP(rs1) && isP(rs2) && sI >= 0 && sI <= 124 && sI % 4 == 0) begin
      t = sI; ok = 1; e = {3'b110, t[5:3], pr(rs1), t[2], t[6], pr(rs2), 2'b00};
    end else if (op == 'h63 && (f3 == 0 || f3 == 1) && rs2 == 0 && isP(rs1) && bI >= -256 && bI <= 254) begin
      t = bI; ok = 1;
      e = {(f3 == 0) ? 3'b110 : 3'b111, t[8], t[4:3], pr(rs1), t[7:6], t[2:1], t[5], 2'b01};
    end else if (op == 'h6f && (rd == 0 || rd == 1) && jI >= -2048 && jI <= 2046) begin
      t = jI; ok = 1;
      e = {(rd == 0) ? 3'b101 : 3'b001, t[11], t[4], t[9:8], t[10], t[6], t[7], t[3:1], t[5], 2'b01};
    end
    return {ok, e};
  endfunction

  function automatic logic [31:0] mkR(int f7, int rs2, int rs1, int f3, int rd, int op);
    logic [31:0] a, b, c, d, e, f;
    a = f7; b = rs2; c = rs1; d = f3; e = rd; f = op;
    return {a[6:0], b[4:0], c[4:0], d[2:0], e[4:0], f[6:0]};
  endfunction

  function automatic logic [31:0] mkI(int imm, int rs1, int f3, int rd, int op);
    logic [31:0] a, c, d, e, f;
    a = imm; c = rs1; d = f3; e = rd; f = op;
    return {a[11:0], c[4:0], d[2:0], e[4:0], f[6:0]};
  endfunction

  function automatic logic [31:0] mkS(int imm, int rs2, int rs1, int f3);
    logic [31:0] a, b, c, d;
    a = imm; b = rs2; c = rs1; d = f3;
    return {a[11:5], b[4:0], c[4:0], d[2:0], a[4:0], 7'h23};
  endfunction

  function automatic logic [31:0] mkB(int off, int rs2, int rs1, int f3);
    logic [31:0] a, b, c, d;
    a = off; b = rs2; c = rs1; d = f3;
    return {a[12], a[10:5], b[4:0], c[4:0], d[2:0], a[4:1], a[11], 7'h63};
  endfunction

  function automatic logic [31:0] mkJ(int off, int rd);
    logic [31:0] a, e;
    a = off; e = rd;
    return {a[20], a[10:1], a[11], a[19:12], e[4:0], 7'h6f};
  endfunction

  task automatic fail(string req, logic [31:0] w, logic [33:0] act, logic [33:0] exp);
    errors++;
    $display("FAIL %s word=%08h actual(v,c,w)=%09h expected=%09h", req, w, act, exp);
  endtask

  task automatic vec(string req, logic [31:0] w);
    logic [16:0] m;
    logic [33:0] exp, act;
    m = model(w);
    @(negedge clk);
    inValid = 1'b1;
    inWord = w;
    @(posedge clk);
    #2;
    exp = {1'b1, m[16], m[16] ? {16'h0, m[15:0]} : w};
    act = {outValid, outCompressed, outWord};
    checks++;
    if (act !== exp) fail(req, w, act, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int immA[10] = '{-33, -32, -1, 0, 1, 31, 32, 100, -2048, 2047};
    int luiA[10] = '{0, 1, 31, 32, 'hFFFFF, 'hFFFE0, 'hFFFDF, 'h80000, 'h7FFFF, 'hFFFF0};
    int memA[8]  = '{0, 4, 124, 128, -4, 2, 64, 60};
    int memR[4]  = '{8, 15, 7, 16};
    int brA[9]   = '{-256, -254, -2, 0, 2, 254, 256, -258, 100};
    int jA[10]   = '{-2048, -2046, -2, 2, 2046, 2048, -2050, 1000, -1000, 0};
    int shA[4]   = '{0, 1, 17, 31};
    logic [31:0] lfsr;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (outValid !== 1'b0 || outCompressed !== 1'b0)
      fail("R1", 32'h0, {outValid, outCompressed, outWord}, 34'h0);
    @(negedge clk) rstN = 1'b1;

    // R1: idle cycle with a compressible word on the bus
    @(negedge clk);
    inValid = 1'b0;
    inWord = mkI(5, 0, 0, 10, 'h13);
    @(posedge clk);
    #2;
    checks++;
    if (outValid !== 1'b0 || outCompressed !== 1'b0)
      fail("R1", inWord, {outValid, outCompressed, outWord}, 34'h0);

    // R4: add forms
    for (int rd = 0; rd < 32; rd++)
      for (int rs2 = 0; rs2 < 32; rs2++) begin
        vec("R4", mkR(0, rs2, 0, 0, rd, 'h33));
        vec("R4", mkR(0, rs2, rd, 0, rd, 'h33));
        vec("R4", mkR(0, rs2, (rd + 1) % 32, 0, rd, 'h33));
      end
    // R5: jump register
    for (int rd = 0; rd < 3; rd++)
      for (int rs1 = 0; rs1 < 32; rs1++) begin
        vec("R5", mkI(0, rs1, 0, rd, 'h67));
        vec("R5", mkI(4, rs1, 0, rd, 'h67));
        vec("R5", mkI(-2, rs1, 0, rd, 'h67));
      end
    // R6: load immediate / add immediate
    for (int rd = 0; rd < 32; rd++)
      for (int k = 0; k < 10; k++) begin
        vec("R6", mkI(immA[k], 0, 0, rd, 'h13));
        vec("R6", mkI(immA[k], rd, 0, rd, 'h13));
        vec("R6", mkI(immA[k], (rd + 3) % 32, 0, rd, 'h13));
      end
    // R7: upper immediate
    for (int rd = 0; rd < 32; rd++)
      for (int k = 0; k < 10; k++) begin
        logic [31:0] u;
        u = luiA[k];
        vec("R7", {u[19:0], rd[4:0], 7'h37});
      end
    // R8: shifts and and-immediate
    for (int rd = 0; rd < 32; rd++) begin
      for (int k = 0; k < 4; k++) begin
        vec("R8", mkR(0, shA[k], rd, 1, rd, 'h13));
        vec("R8", mkR(0, shA[k], rd ^ 1, 1, rd, 'h13));
        vec("R8", mkR(0, shA[k], rd, 5, rd, 'h13));
        vec("R8", mkR(32, shA[k], rd, 5, rd, 'h13));
        vec("R8", mkR(32, shA[k], rd ^ 1, 5, rd, 'h13));
      end
      for (int k = 0; k < 10; k++) begin
        vec("R8", mkI(immA[k], rd, 7, rd, 'h13));
        vec("R8", mkI(immA[k], rd ^ 2, 7, rd, 'h13));
      end
    end
    // R9: word load and store
    for (int rd = 0; rd < 32; rd++)
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 8; k++) begin
          vec("R9", mkI(memA[k], memR[b], 2, rd, 'h03));
          vec("R9", mkS(memA[k], rd, memR[b], 2));
        end
    // R10: register ALU
    for (int op = 0; op < 4; op++)
      for (int rd = 0; rd < 32; rd++)
        for (int rs2 = 0; rs2 < 32; rs2++) begin
          int f3v, f7v;
          f3v = (op == 0) ? 0 : (op == 1) ? 4 : (op == 2) ? 6 : 7;
          f7v = (op == 0) ? 32 : 0;
          vec("R10", mkR(f7v, rs2, rd, f3v, rd, 'h33));
          vec("R10", mkR(f7v, rs2, rd ^ 1, f3v, rd, 'h33));
        end
    // R11: branch on zero
    for (int f3 = 0; f3 < 2; f3++)
      for (int rs1 = 0; rs1 < 32; rs1++)
        for (int k = 0; k < 9; k++) begin
          vec("R11", mkB(brA[k], 0, rs1, f3));
          vec("R11", mkB(brA[k], 8, rs1, f3));
        end
    // R12: jumps
    for (int rdI = 0; rdI < 3; rdI++)
      for (int k = 0; k < 10; k++)
        vec("R12", mkJ(jA[k], (rdI == 2) ? 5 : rdI));
    // R13: incompressible encodings
    vec("R13", mkI(8, 8, 0, 9, 'h03));
    vec("R13", mkI(8, 8, 1, 9, 'h03));
    vec("R13", mkS(8, 9, 8, 0));
    vec("R13", mkS(8, 9, 8, 1));
    vec("R13", mkR(1, 9, 8, 0, 8, 'h33));
    vec("R13", mkR(1, 9, 8, 7, 8, 'h33));
    vec("R13", mkR(32, 3, 8, 1, 8, 'h13));
    vec("R13", mkR(0, 9, 8, 1, 8, 'h33));
    vec("R13", mkB(4, 0, 8, 4));
    vec("R13", mkI(0, 0, 0, 0, 'h73));
    vec("R13", {20'h00001, 5'd8, 7'h17});
    vec("R13", mkI(0, 8, 1, 0, 'h67));
    // R2: pseudo-random words, pass-through or compressed per model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      vec("R2", lfsr);
      vec("R2", {lfsr[31:7], (i % 2 == 0) ? 7'h13 : 7'h33});
    end
    // R1: valid drops again after a burst
    @(negedge clk) inValid = 1'b0;
    @(posedge clk);
    #2;
    checks++;
    if (outValid !== 1'b0 || outCompressed !== 1'b0)
      fail("R1", inWord, {outValid, outCompressed, outWord}, 34'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule